// File: doc/BRIEF.md
# Exhaustive Syndrome Test Unit

This unit exercises a small single-output combinational function with every one of its 2^N input patterns and counts how many of the responses are 1. That count, K, is the numerator of the function's syndrome. The denominator is always 2^N, so it is never stored. When the sweep is over, the unit compares K with an expected count that was captured when the run began. It then raises `done` for one cycle and reports `pass`.

The function under test is a built-in gate. A port picks it from AND, OR, NAND, NOR, XOR, or a composed function made of two disjoint halves joined by XOR. A second port can force the gate output to a stuck-at-0 or stuck-at-1 value, which gives a faulty response to screen out. A run begins with a one-cycle `start` pulse while the unit is idle.

Top module: `syndrome_tester`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge leaves `busy`, `done` and `pass` at 0 and `ones_k` at 0.
- R2: A `start` pulse seen while idle makes `busy` 1 and `vec` 0 in the next cycle. `vec` then steps up by one each cycle up to 2^N-1, so `busy` stays high for exactly 2^N cycles.
- R3: `cut_out` is the selected function of `vec`. The `gate_sel` codes are 0 AND, 1 OR, 2 NAND, 3 NOR and 4 XOR, all over every bit of `vec`. Code 5 is the AND of the low floor(N/2) bits XOR the OR of the remaining upper bits. Any other code gives 0. The `fault_sel` codes are 0 none, 1 stuck-at-0, 2 stuck-at-1 and 3 none.
- R4: `ones_k` is cleared when a run starts and goes up by one for each `busy` cycle in which `cut_out` is 1. After the run it holds K until the next start. It is N+1 bits wide, so K = 2^N can be represented.
- R5: `done` is a single-cycle pulse in the cycle after the last vector, which is also the cycle in which `busy` falls.
- R6: `pass` is set together with `done` to (K == the `expect_k` value sampled with `start`). It is cleared at the next start and holds its value otherwise.
- R7: A `start` pulse during a run is ignored. The run length, K and the captured expected count are unchanged.
- R8: With N=3, fault-free K is 1 for AND, 7 for OR, 7 for NAND, 1 for NOR and 4 for XOR. A stuck-at-0 force gives K = 0 and a stuck-at-1 force gives K = 2^N, so both fail against the AND and OR counts.
- R9: For code 5, K equals K1·2^b + K2·2^a − 2·K1·K2. Here a and b are the widths of the two halves, and K1 and K2 are their own counts. This is the syndrome rule S1 + S2 − 2·S1·S2 scaled by 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a sweep when idle |
| gate_sel | input | 3 | Function select code |
| fault_sel | input | 2 | Output force select code |
| expect_k | input | N+1 | Expected ones count, sampled with start |
| busy | output | 1 | High during the 2^N sweep cycles |
| vec | output | N | Input vector currently applied |
| cut_out | output | 1 | Function response for `vec` |
| ones_k | output | N+1 | Ones count K |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | K matched the expected count |

## Verification
The bench targets the final vector. A counter that stops one vector early or late shows up as a `busy` window that is not 2^N cycles long and as a `done` pulse that is off by a cycle. It also targets the last response. If the compare reads K before the final response has been added, AND reports fail with K = 1. The stuck-at-1 run checks that K = 2^N survives the full width of the count and does not wrap to zero. A `start` pulse in the middle of a run checks that a design which restarts, or which takes the second expected count, changes both the cycle count and `pass`.

// File: rtl/syn_pkg.sv
// Shared codes for the syndrome test unit.
// Assumes the select ports carry these raw codes.
package syn_pkg;

    typedef enum logic [2:0] {
        FN_AND  = 3'd0,
        FN_OR   = 3'd1,
        FN_NAND = 3'd2,
        FN_NOR  = 3'd3,
        FN_XOR  = 3'd4,
        FN_SPLIT = 3'd5
    } fn_code_e;

    typedef enum logic [1:0] {
        FORCE_NONE = 2'd0,
        FORCE_LO   = 2'd1,
        FORCE_HI   = 2'd2,
        FORCE_OFF  = 2'd3
    } force_code_e;

endpackage

// File: rtl/syn_sweep.sv
// Input vector sweeper: walks vec from 0 to 2^N-1, one step per cycle.
// Assumes launch is asserted only while idle.
module syn_sweep #(
    parameter int N_IN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    output logic            busy,
    output logic [N_IN-1:0] vec,
    output logic            last,
    output logic            done
);
    localparam logic [N_IN-1:0] VEC_MAX = {N_IN{1'b1}};

    // Final vector of the sweep is being applied this cycle.
    assign last = busy && (vec == VEC_MAX);

    // Sweep state: run flag, vector index and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            vec  <= '0;
            done <= 1'b0;
        end else begin
            done <= last;
            if (launch) begin
                busy <= 1'b1;
                vec  <= '0;
            end else if (last) begin
                busy <= 1'b0;
            end else if (busy) begin
                vec <= vec + 1'b1;
            end
        end
    end
endmodule

// File: rtl/syn_cut.sv
// Circuit under test: selectable single-output gate plus optional stuck force.
// Assumes N_IN >= 2 so both halves of the composed function are non-empty.
module syn_cut
    import syn_pkg::*;
#(
    parameter int N_IN = 3
) (
    input  logic [N_IN-1:0] vec,
    input  logic [2:0]      gate_sel,
    input  logic [1:0]      fault_sel,
    output logic            cut_out
);
    localparam int LO_W = N_IN / 2;

    logic lo_and;
    logic hi_or;
    logic raw;

    // Split halves of the vector for the composed function.
    assign lo_and = &vec[LO_W-1:0];
    assign hi_or  = |vec[N_IN-1:LO_W];

    // Fault-free response of the selected gate.
    always_comb begin
        case (fn_code_e'(gate_sel))
            FN_AND:   raw = &vec;
            FN_OR:    raw = |vec;
            FN_NAND:  raw = ~&vec;
            FN_NOR:   raw = ~|vec;
            FN_XOR:   raw = ^vec;
            FN_SPLIT: raw = lo_and ^ hi_or;
            default:  raw = 1'b0;
        endcase
    end

    // Optional stuck-at override on the gate output.
    always_comb begin
        case (force_code_e'(fault_sel))
            FORCE_LO: cut_out = 1'b0;
            FORCE_HI: cut_out = 1'b1;
            default:  cut_out = raw;
        endcase
    end
endmodule

// File: rtl/syn_tally.sv
// Ones accumulator and final compare.
// Assumes bit_in is valid whenever busy is high.
module syn_tally #(
    parameter int N_IN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          busy,
    input  logic          last,
    input  logic          bit_in,
    input  logic [N_IN:0] expect_k,
    output logic [N_IN:0] ones_k,
    output logic          pass
);
    logic [N_IN:0] exp_q;
    logic [N_IN:0] k_next;

    // Count including the response of the current cycle.
    assign k_next = ones_k + {{N_IN{1'b0}}, bit_in};

    // Tally ones, capture the expected count, settle the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_k <= '0;
            exp_q  <= '0;
            pass   <= 1'b0;
        end else if (launch) begin
            ones_k <= '0;
            exp_q  <= expect_k;
            pass   <= 1'b0;
        end else if (busy) begin
            ones_k <= k_next;
            if (last) begin
                pass <= (k_next == exp_q);
            end
        end
    end
endmodule

// File: rtl/syndrome_tester.sv
// Exhaustive syndrome test unit top: sweeps all 2^N vectors through the
// selected gate, counts ones and compares with an expected count.
// Assumes start is a pulse; a pulse during a run is dropped.
module syndrome_tester #(
    parameter int N_IN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      gate_sel,
    input  logic [1:0]      fault_sel,
    input  logic [N_IN:0]   expect_k,
    output logic            busy,
    output logic [N_IN-1:0] vec,
    output logic            cut_out,
    output logic [N_IN:0]   ones_k,
    output logic            done,
    output logic            pass
);
    logic launch;
    logic last;

    // A run begins only from idle.
    assign launch = start && !busy;

    syn_sweep #(.N_IN(N_IN)) u_sweep (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .busy(busy), .vec(vec), .last(last), .done(done)
    );

    syn_cut #(.N_IN(N_IN)) u_cut (
        .vec(vec), .gate_sel(gate_sel), .fault_sel(fault_sel),
        .cut_out(cut_out)
    );

    syn_tally #(.N_IN(N_IN)) u_tally (
        .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy),
        .last(last), .bit_in(cut_out), .expect_k(expect_k),
        .ones_k(ones_k), .pass(pass)
    );
endmodule

// File: rtl/syn_chk.sv
// Temporal checks on the syndrome test unit ports, bound to the top.
module syn_chk #(
    parameter int N_IN = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic [N_IN-1:0] vec,
    input logic            cut_out,
    input logic [N_IN:0]   ones_k,
    input logic            done,
    input logic            pass
);
    localparam logic [N_IN-1:0] VEC_MAX = {N_IN{1'b1}};

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !pass && ones_k == '0));

    a_r2_first_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && vec == '0));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && vec != VEC_MAX) |=> (busy && vec == N_IN'($past(vec) + 1'b1)));

    a_r4_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (ones_k == ($past(ones_k) + {{N_IN{1'b0}}, $past(cut_out)})));

    a_r5_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && vec == VEC_MAX) |=> (done && !busy));

    a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(busy && vec == VEC_MAX) && !(start && !busy)) |=> $stable(pass));

    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && vec != VEC_MAX) |=> (busy && vec != '0));
endmodule

bind syndrome_tester syn_chk #(.N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .vec(vec),
    .cut_out(cut_out), .ones_k(ones_k), .done(done), .pass(pass)
);

// File: tb/syndrome_tester_tb.sv
module syndrome_tester_tb;
    localparam int N = 3;
    localparam int VMAX = (1 << N) - 1;
    localparam int LO = N / 2;
    localparam int HI = N - LO;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   gate_sel = 3'd0;
    logic [1:0]   fault_sel = 2'd0;
    logic [N:0]   expect_k = '0;
    logic         busy;
    logic [N-1:0] vec;
    logic         cut_out;
    logic [N:0]   ones_k;
    logic         done;
    logic         pass;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state
    bit m_busy = 0;
    int m_vec = 0;
    int m_k = 0;
    bit m_done = 0;
    bit m_pass = 0;
    int m_exp = 0;

    always #10 clk = ~clk;

    syndrome_tester #(.N_IN(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gate_sel(gate_sel),
        .fault_sel(fault_sel), .expect_k(expect_k), .busy(busy), .vec(vec),
        .cut_out(cut_out), .ones_k(ones_k), .done(done), .pass(pass)
    );

    function automatic bit ref_out(int g, int f, int v);
        int ones = 0;
        bit lo_all = 1;
        bit hi_any = 0;
        bit r;
        for (int i = 0; i < N; i++) begin
            if ((v >> i) & 1) ones++;
            if (i < LO && !((v >> i) & 1)) lo_all = 0;
            if (i >= LO && ((v >> i) & 1)) hi_any = 1;
        end
        case (g)
            0: r = (ones == N);
            1: r = (ones != 0);
            2: r = (ones != N);
            3: r = (ones == 0);
            4: r = ones[0];
            5: r = lo_all ^ hi_any;
            default: r = 0;
        endcase
        if (f == 1) r = 0;
        else if (f == 2) r = 1;
        return r;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model update on each edge, compare 5 ns later
    always @(posedge clk) begin
        bit launch;
        if (!rst_n) begin
            m_busy = 0; m_vec = 0; m_k = 0; m_done = 0; m_pass = 0; m_exp = 0;
        end else begin
            launch = start && !m_busy;
            m_done = 0;
            if (launch) begin
                m_busy = 1; m_vec = 0; m_k = 0; m_exp = int'(expect_k); m_pass = 0;
            end else if (m_busy) begin
                m_k += ref_out(gate_sel, fault_sel, m_vec);
                if (m_vec == VMAX) begin
                    m_busy = 0; m_done = 1; m_pass = (m_k == m_exp);
                end else begin
                    m_vec++;
                end
            end
        end
        #5;
        if (rst_n) begin
            check("R2", busy, m_busy, "busy");
            if (m_busy) begin
                check("R2", vec, m_vec, "vec");
                check("R3", cut_out, ref_out(gate_sel, fault_sel, m_vec), "cut_out");
            end
            check("R4", ones_k, m_k, "ones_k");
            check("R5", done, m_done, "done");
            check("R6", pass, m_pass, "pass");
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(int g, int f, int ek, int want_k, bit want_pass, string req);
        int len = 0;
        @(negedge clk);
        gate_sel = 3'(g); fault_sel = 2'(f); expect_k = (N+1)'(ek); start = 1;
        @(negedge clk);
        start = 0;
        while (!done) begin
            if (busy) len++;
            @(negedge clk);
        end
        check("R2", len, VMAX + 1, "busy length");
        check(req, ones_k, want_k, "final K");
        check(req, pass, want_pass, "verdict");
    endtask

    initial begin
        int kc;
        repeat (3) @(negedge clk);
        check("R1", {busy, done, pass}, 0, "flags after reset");
        check("R1", ones_k, 0, "ones_k after reset");
        rst_n = 1;

        run(0, 0, 1, 1, 1, "R8");   // AND
        run(1, 0, 7, 7, 1, "R8");   // OR
        run(2, 0, 7, 7, 1, "R8");   // NAND
        run(3, 0, 1, 1, 1, "R8");   // NOR
        run(4, 0, 4, 4, 1, "R8");   // XOR
        run(4, 0, 3, 4, 0, "R6");   // wrong expectation fails
        kc = 1 * (1 << HI) + ((1 << HI) - 1) * (1 << LO) - 2 * 1 * ((1 << HI) - 1);
        run(5, 0, kc, kc, 1, "R9"); // composed function
        run(0, 1, 1, 0, 0, "R8");   // AND stuck-at-0
        run(0, 2, 1, 8, 0, "R8");   // AND stuck-at-1, K = 2^N
        run(1, 1, 7, 0, 0, "R8");   // OR stuck-at-0
        run(1, 2, 7, 8, 0, "R8");   // OR stuck-at-1
        run(0, 3, 1, 1, 1, "R3");   // code 3 is no force
        run(7, 0, 0, 0, 1, "R3");   // unused gate code outputs 0

        // R6: verdict held while idle
        repeat (4) @(negedge clk);
        check("R6", pass, 1, "pass held idle");
        check("R4", ones_k, 0, "ones_k held idle");

        // R7: start during a run is ignored
        @(negedge clk);
        gate_sel = 3'd1; fault_sel = 2'd0; expect_k = 4'd7; start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        expect_k = 4'd2; start = 1;
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        check("R7", ones_k, 7, "K after mid-run start");
        check("R7", pass, 1, "verdict uses first expectation");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule